// File: doc/BRIEF.md
# Round-Trip Propagation Delay Estimator

This block finds the one-way radio path length to a single neighbour, counted in timer ticks, while a network is being set up. A node acting as initiator zeroes a local timer and fires its transmitter. The neighbour, acting as responder, sees the burst and answers at once. The initiator then reads its timer at the moment the reply's peak-detect pulse arrives. The timer runs on the correlator clock, so one tick is one correlator cycle (3.2 ns at 312.5 MHz).

The initiator collects sixteen good round trips. It sums them in a wide accumulator and divides by sixteen with a 4-bit right shift. The quotient is written once into the per-neighbour delay memory at the index given at start, and the consensus correction reads it from there later. A missing reply ends its trial at a fixed timeout. That trial is retried and is not counted. Four misses in a row abandon the run and raise an error flag. In the responder role the block answers sixteen peaks and then reports completion.

Top module: `rt_delay_estimator`

## Requirements
- R1: After reset, txTrig, memWrEn, done and errFlag are all low, and the block is idle.
- R2: A start accepted with roleResp low (initiator) drives txTrig high for exactly one cycle, in the cycle after the start is sampled. The local timer reads zero in that cycle.
- R3: The initiator's captured sample equals the number of cycles from its txTrig cycle to the cycle in which peakDet is sampled high. A peakDet that is high in the txTrig cycle itself is ignored.
- R4: After the 16th valid sample, memWrEn is high for one cycle, in the cycle after that peak. memWrAddr then carries the neighbour index latched at start, and memWrData carries floor(sum of the 16 samples / 16). After any earlier sample, the next txTrig follows in the cycle after the peak.
- R5: A peak that arrives up to TIMEOUT_CYC cycles after txTrig is accepted. If no peak arrives by then, txTrig repeats TIMEOUT_CYC+1 cycles after the previous one, and the lost trial is not counted.
- R6: Four consecutive timeouts end the run: no further txTrig, no memory write, no done, and errFlag goes high in the cycle after the fourth timeout. A valid sample resets the run of misses. errFlag clears when the next start is accepted.
- R7: With roleResp high at start (responder), each sampled peakDet is answered by txTrig in the next cycle. done is asserted together with the 16th answer, and memWrEn never rises in this role.
- R8: While a run is in progress, startReq, roleResp and neighIdx are ignored. The write still goes to the neighbour latched at start.
- R9: done is a single-cycle pulse, and memWrEn is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Correlator clock; also the timer tick |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a run; sampled only while idle |
| roleResp | input | 1 | Role at start: 0 initiator, 1 responder |
| neighIdx | input | NEIGH_W | Neighbour slot to be written with the result |
| peakDet | input | 1 | One-cycle pulse from the peak detector |
| txTrig | output | 1 | One-cycle request to send the timing sequence |
| memWrEn | output | 1 | Write strobe to the neighbour delay memory |
| memWrAddr | output | NEIGH_W | Neighbour slot for the write |
| memWrData | output | TIMER_W | Averaged round-trip delay in timer ticks |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Run abandoned after four misses in a row; held until the next start |

## Verification
The assertions take two things for granted: peakDet comes as isolated single-cycle pulses, and the reply delay never exceeds the timer range. On those assumptions the timer bound in the wait state and the single-cycle transmit and completion strobes hold. The stimulus model mimics the remote node. It fires one peak a chosen number of cycles after each observed txTrig, with every delay between 1 and TIMEOUT_CYC. A negative delay stands for a lost reply, and in that case the model stays silent for the whole timeout window. All inputs change on falling edges, and the reply spacing in the responder test leaves the block back in its listening state before each new peak.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

  // Fixed by the protocol: sixteen round trips per neighbour.
  localparam int TRIALS_LOG2 = 4;
  localparam int MISS_LIMIT  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_STORE,
    ST_LISTEN,
    ST_REPLY
  } rtdState_t;

  typedef struct packed {
    logic latchCfg;   // capture neighbour index
    logic clrStats;   // zero accumulator and counters
    logic clrTimer;   // timer reads zero next cycle
    logic capture;    // add timer into accumulator, count sample
    logic missInc;    // count a timed-out trial
    logic replyInc;   // count a responder answer
  } rtdStrobe_t;

endpackage

// File: rtl/rtd_datapath.sv
module rtd_datapath
  import rtd_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int NEIGH_W     = 3,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic               clk,
  input  logic               rstN,
  input  rtdStrobe_t         strb,
  input  logic [NEIGH_W-1:0] neighIdx,
  output logic [TIMER_W-1:0] timerVal,
  output logic               lastSample,
  output logic               lastMiss,
  output logic               timeoutHit,
  output logic [TIMER_W-1:0] avgOut,
  output logic [NEIGH_W-1:0] neighOut
);

  localparam int ACC_W  = TIMER_W + TRIALS_LOG2;
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  logic [TIMER_W-1:0]     timerQ;
  logic [ACC_W-1:0]       accQ;
  logic [TRIALS_LOG2-1:0] cntQ;
  logic [MISS_W-1:0]      missQ;
  logic [NEIGH_W-1:0]     neighQ;

  // Free-running tick counter, saturating so it never wraps to a false zero.
  always_ff @(posedge clk) begin
    if (!rstN)              timerQ <= '0;
    else if (strb.clrTimer) timerQ <= '0;
    else if (timerQ != '1)  timerQ <= timerQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              accQ <= '0;
    else if (strb.clrStats) accQ <= '0;
    else if (strb.capture)  accQ <= accQ + ACC_W'(timerQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             cntQ <= '0;
    else if (strb.clrStats)                cntQ <= '0;
    else if (strb.capture | strb.replyInc) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            missQ <= '0;
    else if (strb.clrStats | strb.capture) missQ <= '0;
    else if (strb.missInc)                missQ <= missQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              neighQ <= '0;
    else if (strb.latchCfg) neighQ <= neighIdx;
  end

  assign timerVal   = timerQ;
  assign lastSample = &cntQ;
  assign lastMiss   = (missQ == MISS_W'(MISS_LIMIT - 1));
  assign timeoutHit = (timerQ == TIMER_W'(TIMEOUT_CYC));
  assign avgOut     = accQ[ACC_W-1:TRIALS_LOG2];
  assign neighOut   = neighQ;

  // The miss count stays below the limit: the last miss ends the run instead.
  AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    missQ < MISS_W'(MISS_LIMIT)) else $error("miss count overflow"); // R6

  // A capture never lands on a cleared timer, because the peak in the send cycle is ignored.
  AST_CAPTURE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> timerQ != '0) else $error("zero-length sample"); // R3

endmodule

// File: rtl/rtd_ctrl.sv
module rtd_ctrl
  import rtd_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               roleResp,
  input  logic               peakDet,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic               lastSample,
  input  logic               lastMiss,
  input  logic               timeoutHit,
  output rtdStrobe_t         strb,
  output logic               txTrig,
  output logic               memWrEn,
  output logic               done,
  output logic               errFlag,
  output logic               busy
);

  rtdState_t stateQ, stateD;
  logic      errQ;
  logic      giveUp;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    giveUp = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (startReq) begin
        strb.latchCfg = 1'b1;
        strb.clrStats = 1'b1;
        if (roleResp) stateD = ST_LISTEN;
        else begin
          strb.clrTimer = 1'b1;
          stateD        = ST_SEND;
        end
      end
      ST_SEND: stateD = ST_WAIT;
      ST_WAIT: begin
        if (peakDet) begin
          strb.capture = 1'b1;
          if (lastSample) stateD = ST_STORE;
          else begin
            strb.clrTimer = 1'b1;
            stateD        = ST_SEND;
          end
        end else if (timeoutHit) begin
          if (lastMiss) begin
            giveUp = 1'b1;
            stateD = ST_IDLE;
          end else begin
            strb.missInc  = 1'b1;
            strb.clrTimer = 1'b1;
            stateD        = ST_SEND;
          end
        end
      end
      ST_STORE: stateD = ST_IDLE;
      ST_LISTEN: if (peakDet) begin
        strb.clrTimer = 1'b1;
        stateD        = ST_REPLY;
      end
      ST_REPLY: begin
        strb.replyInc = 1'b1;
        stateD        = lastSample ? ST_IDLE : ST_LISTEN;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           errQ <= 1'b0;
    else if (stateQ == ST_IDLE && startReq) errQ <= 1'b0;
    else if (giveUp)                     errQ <= 1'b1;
  end

  assign txTrig  = (stateQ == ST_SEND) || (stateQ == ST_REPLY);
  assign memWrEn = (stateQ == ST_STORE);
  assign done    = (stateQ == ST_STORE) || (stateQ == ST_REPLY && lastSample);
  assign errFlag = errQ;
  assign busy    = (stateQ != ST_IDLE);

  AST_TX_ZERO_TIMER: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SEND) |-> timerVal == '0) else $error("timer not zero at send"); // R2

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txTrig |=> !txTrig) else $error("transmit trigger longer than one cycle"); // R2

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT) |-> timerVal <= TIMER_W'(TIMEOUT_CYC)) else $error("wait past timeout"); // R5

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(stateQ == ST_WAIT && timeoutHit && !peakDet)) else $error("error without timeout"); // R6

  AST_WR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> done) else $error("write without done"); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R9

endmodule

// File: rtl/rt_delay_estimator.sv
module rt_delay_estimator
  import rtd_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int NEIGH_W     = 3,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               roleResp,
  input  logic [NEIGH_W-1:0] neighIdx,
  input  logic               peakDet,
  output logic               txTrig,
  output logic               memWrEn,
  output logic [NEIGH_W-1:0] memWrAddr,
  output logic [TIMER_W-1:0] memWrData,
  output logic               done,
  output logic               errFlag
);

  rtdStrobe_t         strb;
  logic [TIMER_W-1:0] timerVal;
  logic               lastSample, lastMiss, timeoutHit, busy;

  rtd_ctrl #(
    .TIMER_W    (TIMER_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .roleResp  (roleResp),
    .peakDet   (peakDet),
    .timerVal  (timerVal),
    .lastSample(lastSample),
    .lastMiss  (lastMiss),
    .timeoutHit(timeoutHit),
    .strb      (strb),
    .txTrig    (txTrig),
    .memWrEn   (memWrEn),
    .done      (done),
    .errFlag   (errFlag),
    .busy      (busy)
  );

  rtd_datapath #(
    .TIMER_W    (TIMER_W),
    .NEIGH_W    (NEIGH_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .neighIdx  (neighIdx),
    .timerVal  (timerVal),
    .lastSample(lastSample),
    .lastMiss  (lastMiss),
    .timeoutHit(timeoutHit),
    .avgOut    (memWrData),
    .neighOut  (memWrAddr)
  );

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(memWrAddr)) else $error("neighbour changed mid-run"); // R8

endmodule

// File: tb/rt_delay_estimator_bench.sv
module rt_delay_estimator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TW  = 16;
  localparam int NW  = 3;
  localparam int TMO = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          roleResp = 1'b0;
  logic [NW-1:0] neighIdx = '0;
  logic          peakDet = 1'b0;
  logic          txTrig, memWrEn, done, errFlag;
  logic [NW-1:0] memWrAddr;
  logic [TW-1:0] memWrData;

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_delay_estimator #(.TIMER_W(TW), .NEIGH_W(NW), .TIMEOUT_CYC(TMO)) u_rt_delay_estimator (
    .clk(clk), .rstN(rstN), .startReq(startReq), .roleResp(roleResp),
    .neighIdx(neighIdx), .peakDet(peakDet), .txTrig(txTrig), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .done(done), .errFlag(errFlag)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int    addr;
    int    data;
    string tag;
  } wrItem_t;
  wrItem_t expQ[$];
  wrItem_t cur;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: every write is compared against the oldest expected item.
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (expQ.size() == 0) check(1'b0, "R6 unexpected write", int'(memWrAddr), -1);
      else begin
        cur = expQ.pop_front();
        check(int'(memWrAddr) == cur.addr, {cur.tag, " write address"}, int'(memWrAddr), cur.addr);
        check(int'(memWrData) == cur.data, {"R4 average ", cur.tag}, int'(memWrData), cur.data);
        check(done == 1'b1, "R9 done with write", int'(done), 1);
      end
    end
  end

  task automatic issueStart(int n, bit resp);
    neighIdx = NW'(n);
    roleResp = resp;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // Entered at the falling edge of a txTrig cycle. d<0: reply lost; early: spurious peak in the send cycle.
  task automatic trial(int d, bit early);
    check(txTrig == 1'b1, "R2 transmit trigger", int'(txTrig), 1);
    if (d < 0) begin
      repeat (TMO + 1) @(negedge clk);
    end else begin
      if (early) peakDet = 1'b1;
      @(negedge clk);
      peakDet = 1'b0;
      check(txTrig == 1'b0, "R2 single-cycle trigger", int'(txTrig), 0);
      repeat (d - 1) @(negedge clk);
      peakDet = 1'b1;
      @(negedge clk);
      peakDet = 1'b0;
    end
  endtask

  // Driver: one initiator run, misses given as -1 inside the list.
  task automatic measure(int n, int ds[], bit disturb, string tag);
    int sum = 0;
    int valid = 0;
    wrItem_t it;
    foreach (ds[i]) if (ds[i] >= 0) sum += ds[i];
    it.addr = n; it.data = sum / 16; it.tag = tag;
    expQ.push_back(it);
    issueStart(n, 1'b0);
    check(errFlag == 1'b0, "R6 error cleared on start", int'(errFlag), 0);
    if (disturb) begin
      startReq = 1'b1; neighIdx = NW'(n + 1); roleResp = 1'b1;
    end
    foreach (ds[i]) begin
      if (ds[i] >= 0) valid++;
      if (valid == 16) startReq = 1'b0;
      trial(ds[i], (i % 5) == 2);
    end
    check(memWrEn == 1'b1, "R4 write after 16th sample", int'(memWrEn), 1);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);
    check(txTrig == 1'b0, "R4 no transmit after store", int'(txTrig), 0);
    check(errFlag == 1'b0, "R6 no error", int'(errFlag), 0);
  endtask

  initial begin
    int ds[];
    repeat (4) @(negedge clk);
    check(txTrig == 1'b0, "R1 reset txTrig", int'(txTrig), 0);
    check(memWrEn == 1'b0, "R1 reset memWrEn", int'(memWrEn), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(errFlag == 1'b0, "R1 reset errFlag", int'(errFlag), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(txTrig == 1'b0, "R1 idle after reset", int'(txTrig), 0);

    // R3: constant delay, early peaks ignored
    ds = new[16];
    foreach (ds[i]) ds[i] = 7;
    measure(3, ds, 1'b0, "R3");

    // R4: varied delays, floor of the mean
    foreach (ds[i]) ds[i] = 1 + ((i * 5) % 37);
    measure(5, ds, 1'b0, "R4");

    // R5/R6: timeouts retried, boundary delay accepted, miss run reset by a sample
    ds = new[22];
    foreach (ds[i]) ds[i] = 3 + i;
    ds[0] = -1; ds[1] = -1; ds[2] = -1;
    ds[3] = TMO;
    ds[4] = -1; ds[5] = -1; ds[6] = -1;
    measure(6, ds, 1'b0, "R5");

    // R6: four misses in a row abandon the run
    issueStart(2, 1'b0);
    for (int k = 0; k < 4; k++) trial(-1, 1'b0);
    check(errFlag == 1'b1, "R6 error after four misses", int'(errFlag), 1);
    check(txTrig == 1'b0, "R6 no retry after abort", int'(txTrig), 0);
    repeat (TMO) @(negedge clk);
    check(txTrig == 1'b0, "R6 stays idle", int'(txTrig), 0);
    check(errFlag == 1'b1, "R6 error held", int'(errFlag), 1);

    // R8: start, role and index changes during a run are ignored
    ds = new[16];
    foreach (ds[i]) ds[i] = 10 + (i % 4);
    measure(1, ds, 1'b1, "R8");

    // R7: responder answers sixteen peaks
    issueStart(4, 1'b1);
    for (int k = 0; k < 16; k++) begin
      repeat (3 + (k % 4)) @(negedge clk);
      check(txTrig == 1'b0, "R7 silent while listening", int'(txTrig), 0);
      peakDet = 1'b1;
      @(negedge clk);
      peakDet = 1'b0;
      check(txTrig == 1'b1, "R7 answer next cycle", int'(txTrig), 1);
      check(done == (k == 15), "R7 done with 16th answer", int'(done), int'(k == 15));
      check(memWrEn == 1'b0, "R7 no write as responder", int'(memWrEn), 0);
    end
    @(negedge clk);
    check(done == 1'b0, "R9 responder done one cycle", int'(done), 0);
    peakDet = 1'b1;
    @(negedge clk);
    peakDet = 1'b0;
    check(txTrig == 1'b0, "R7 no answer after done", int'(txTrig), 0);

    check(expQ.size() == 0, "R4 all writes seen", expQ.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule